// File: doc/BRIEF.md
# Bit-Masked Byte-Lane Memory

This block is a synchronous memory addressed in bytes. One write port takes a 32-bit word, a 4-bit lane enable and a 32-bit bit mask. Only the bits selected by the mask change, and only within the lanes that are enabled. Every other stored bit keeps its value. This lets a client update a sub-byte field, such as a 4-bit pixel index packed two per byte, without reading the byte first. The read-modify-write happens inside the memory on the clock edge.

Two read ports return whole words without a clock. Each one ignores the two low address bits, and each can look at any word while a write is under way. The capacity is a power-of-two parameter in bytes, 4096 by default. The address ports are exactly wide enough for that capacity, so byte addresses wrap modulo the size. Reset does not clear the contents.

The interface is plain. There is no valid/ready handshake, because each write completes in one cycle and can never stall.

Top module: `brm_mem`

## Requirements
- R1: On a clock edge with `wr_en_i` high, each lane k with `wr_be_i[k]` set stores `(old & ~m) | (d & m)`. Here `d` is `wr_data_i[8k+7:8k]` and `m` is `wr_mask_i[8k+7:8k]`.
- R2: With `wr_be_i` = 4'b0001 and a mask of all ones, the addressed byte takes `wr_data_i[7:0]` and no other byte changes.
- R3: Writes to the same byte in consecutive cycles compose. A low-nibble write of 3 (mask 0x0F) followed by a high-nibble write of C (mask 0xF0) over a stored 0xA5 leaves 0xC3.
- R4: A read returns the word at `addr & ~3`, with byte n of that word on bits [8n+7:8n]. Address bits [1:0] have no effect on the result.
- R5: Memory contents do not change in any of these cases: `wr_en_i` is low, the lane enable is zero, the mask bits are zero, or the byte is not addressed by the write.
- R6: Write lane k goes to byte address `wr_addr_i + k`, so an unaligned write spans two words.
- R7: A byte address past the capacity wraps modulo the size. For example, lane 1 of a write at the last byte lands on byte 0.
- R8: The second read port returns the same contents as the first, at its own independent address.
- R9: Asserting reset leaves the stored contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Active-low reset; gates checks only, contents are kept |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | IDX_W | Byte address of write lane 0 |
| wr_data_i | input | 32 | Write data, lane k on bits [8k+7:8k] |
| wr_be_i | input | 4 | Lane enables |
| wr_mask_i | input | 32 | Bit mask, one bit per data bit |
| rda_addr_i | input | IDX_W | Read port A byte address (word aligned internally) |
| rda_data_o | output | 32 | Read port A word |
| rdb_addr_i | input | IDX_W | Read port B byte address (word aligned internally) |
| rdb_data_o | output | 32 | Read port B word |

## Verification
Two cases are hard to reach from the ports. The first is a pair of sub-byte writes to the same byte in back-to-back cycles, where the second merge must see the result of the first. The second is a write whose upper lanes run past the end of the memory. The bench first fills every byte with a known pattern, so any bit that is clobbered shows up. It then issues the two nibble writes on consecutive clock cycles with no idle cycle between them. It also places an unaligned full-word write at the final bytes of the address space and reads back both the last word and word zero.

// File: rtl/brm_pkg.sv
package brm_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic lane_t bit_merge(lane_t old_v, lane_t new_v, lane_t sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction
endpackage

// File: rtl/brm_merge.sv
module brm_merge
  import brm_pkg::*;
(
  input  word_t old_i,
  input  word_t data_i,
  input  word_t mask_i,
  output word_t merged_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged_o[k*LANE_W +: LANE_W] =
      bit_merge(old_i[k*LANE_W +: LANE_W], data_i[k*LANE_W +: LANE_W],
                mask_i[k*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/brm_rd_port.sv
module brm_rd_port
  import brm_pkg::*;
#(
  parameter int unsigned BYTES = 4096,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  lane_t            mem_i [BYTES],
  input  logic [IDX_W-1:0] addr_i,
  output word_t            data_o
);
  localparam logic [IDX_W-1:0] ALIGN_MASK = ~IDX_W'(LANES - 1);

  logic [IDX_W-1:0] base;
  assign base = addr_i & ALIGN_MASK;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign data_o[k*LANE_W +: LANE_W] = mem_i[base + IDX_W'(k)];
  end
endmodule

// File: rtl/brm_mem.sv
module brm_mem
  import brm_pkg::*;
#(
  parameter int unsigned BYTES = 4096,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [LANES-1:0]   wr_be_i,
  input  logic [WORD_W-1:0]  wr_mask_i,
  input  logic [IDX_W-1:0]   rda_addr_i,
  output logic [WORD_W-1:0]  rda_data_o,
  input  logic [IDX_W-1:0]   rdb_addr_i,
  output logic [WORD_W-1:0]  rdb_data_o
);
  lane_t            store [BYTES];
  logic [IDX_W-1:0] lane_idx [LANES];
  word_t            old_word;
  word_t            new_word;

  // Lane k targets wr_addr + k; the narrow index wraps modulo BYTES.
  for (genvar k = 0; k < LANES; k++) begin : g_idx
    assign lane_idx[k] = wr_addr_i + IDX_W'(k);
    assign old_word[k*LANE_W +: LANE_W] = store[lane_idx[k]];
  end

  brm_merge u_merge (
    .old_i   (old_word),
    .data_i  (wr_data_i),
    .mask_i  (wr_mask_i),
    .merged_o(new_word)
  );

  // No reset on storage: contents survive rst_ni.
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (wr_be_i[k]) store[lane_idx[k]] <= new_word[k*LANE_W +: LANE_W];
      end
    end
  end

  brm_rd_port #(.BYTES(BYTES)) u_rda (
    .mem_i (store),
    .addr_i(rda_addr_i),
    .data_o(rda_data_o)
  );

  brm_rd_port #(.BYTES(BYTES)) u_rdb (
    .mem_i (store),
    .addr_i(rdb_addr_i),
    .data_o(rdb_data_o)
  );

  // R1: aligned lane-0 write seen on port A follows the bit merge.
  a_r1_lane0_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && wr_be_i[0] && (wr_addr_i[1:0] == 2'b00)) && $stable(rda_addr_i) &&
     ((rda_addr_i >> 2) == ($past(wr_addr_i) >> 2)))
    |-> (rda_data_o[7:0] == (($past(rda_data_o[7:0]) & ~$past(wr_mask_i[7:0])) |
                              ($past(wr_data_i[7:0]) & $past(wr_mask_i[7:0])))));

  // R2: full-mask single-lane write replaces byte 0, other bytes hold.
  a_r2_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && (wr_be_i == 4'b0001) && (wr_mask_i == '1) && (wr_addr_i[1:0] == 2'b00)) &&
     $stable(rda_addr_i) && ((rda_addr_i >> 2) == ($past(wr_addr_i) >> 2)))
    |-> (rda_data_o[7:0] == $past(wr_data_i[7:0]) &&
         rda_data_o[31:8] == $past(rda_data_o[31:8])));

  // R5: idle cycle leaves read data unchanged.
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && $stable(rda_addr_i)) |-> $stable(rda_data_o));

  // R5: a write with no lane enabled or an all-zero mask changes nothing.
  a_r5_noop_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && ((wr_be_i == '0) || (wr_mask_i == '0))) && $stable(rda_addr_i))
    |-> $stable(rda_data_o));

  // R8: both ports agree on the same address.
  a_r8_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rda_addr_i == rdb_addr_i) |-> (rda_data_o == rdb_data_o));
endmodule

// File: tb/sim_brm_mem.sv
`timescale 1ns/1ps
module sim_brm_mem;
  localparam int unsigned BYTES = 4096;
  localparam int unsigned IDX_W = $clog2(BYTES);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [IDX_W-1:0] wr_addr, rda_addr, rdb_addr;
  logic [31:0] wr_data, wr_mask, rda_data, rdb_data;
  logic [3:0]  wr_be;

  always #10 clk = ~clk;

  brm_mem #(.BYTES(BYTES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_mask_i(wr_mask),
    .rda_addr_i(rda_addr), .rda_data_o(rda_data),
    .rdb_addr_i(rdb_addr), .rdb_data_o(rdb_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] sh [BYTES];

  function automatic logic [31:0] exp_word(input int a);
    int b = a & ~3;
    return {sh[b+3], sh[b+2], sh[b+1], sh[b]};
  endfunction

  function automatic void model_write(input int a, input logic [31:0] d,
                                      input logic [3:0] be, input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        int i = (a + k) % BYTES;
        sh[i] = (sh[i] & ~m[8*k +: 8]) | (d[8*k +: 8] & m[8*k +: 8]);
      end
    end
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Reads both ports at a negedge, after any write has committed.
  task automatic look(input string req, input int a, input logic [31:0] exp);
    rda_addr = IDX_W'(a);
    rdb_addr = IDX_W'(a);
    #1;
    check(req, rda_data, exp);
  endtask

  task automatic put(input int a, input logic [31:0] d, input logic [3:0] be,
                     input logic [31:0] m, input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = IDX_W'(a); wr_data = d; wr_be = be; wr_mask = m;
    if (en) model_write(a, d, be, m);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_fill;
    for (int w = 0; w < BYTES; w += 4) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = IDX_W'(w); wr_data = 32'hA5A5_A5A5;
      wr_be = 4'hF; wr_mask = 32'hFFFF_FFFF;
      model_write(w, 32'hA5A5_A5A5, 4'hF, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    wr_en = 1'b0;
    look("R5 fill first", 0, 32'hA5A5_A5A5);
    look("R5 fill last", BYTES - 4, 32'hA5A5_A5A5);
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look("R9 contents after reset", 0, 32'hA5A5_A5A5);
  endtask

  task automatic t_bit_merge;
    put(8, 32'h1234_5678, 4'b1011, 32'h0F0F_F0F0, 1'b1);
    // lane0 A5->(A5&0F)|(78&F0)=75, lane1 ->(A5&0F)|(56&F0)=55, lane2 kept, lane3 A5&F0|12&0F=A2
    look("R1 masked lanes", 8, 32'hA2A5_5575);
    check("R1 model", rda_data, exp_word(8));
  endtask

  task automatic t_byte_write;
    put(21, 32'hDEAD_BE3C, 4'b0001, 32'hFFFF_FFFF, 1'b1);
    look("R2 single byte", 20, 32'hA5A5_3CA5);
  endtask

  task automatic t_compose;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IDX_W'(50); wr_data = 32'h0000_0003; wr_be = 4'b0001; wr_mask = 32'h0000_000F;
    model_write(50, 32'h3, 4'b0001, 32'hF);
    @(negedge clk);
    wr_data = 32'h0000_00C0; wr_mask = 32'h0000_00F0;
    model_write(50, 32'hC0, 4'b0001, 32'hF0);
    @(negedge clk);
    wr_en = 1'b0;
    look("R3 back-to-back nibbles", 48, 32'hA5C3_A5A5);
  endtask

  task automatic t_lane_order;
    put(64, 32'h4433_2211, 4'hF, 32'hFFFF_FFFF, 1'b1);
    look("R4 aligned read", 64, 32'h4433_2211);
    look("R4 low bits ignored", 67, 32'h4433_2211);
  endtask

  task automatic t_unaligned;
    put(97, 32'hAABB_CCDD, 4'hF, 32'hFFFF_FFFF, 1'b1);
    look("R6 first word", 96, 32'hBBCC_DDA5);
    look("R6 second word", 100, 32'hA5A5_A5AA);
  endtask

  task automatic t_wrap;
    put(BYTES - 2, 32'h1122_3344, 4'hF, 32'hFFFF_FFFF, 1'b1);
    look("R7 last word", BYTES - 4, 32'h3344_A5A5);
    look("R7 wrapped to zero", 0, 32'hA5A5_1122);
  endtask

  task automatic t_second_port;
    rda_addr = IDX_W'(64);
    rdb_addr = IDX_W'(98);
    #1;
    check("R8 port A", rda_data, 32'h4433_2211);
    check("R8 port B", rdb_data, 32'hBBCC_DDA5);
  endtask

  task automatic t_no_effect;
    put(200, 32'h0, 4'hF, 32'hFFFF_FFFF, 1'b0);
    look("R5 wr_en low", 200, 32'hA5A5_A5A5);
    put(200, 32'h0, 4'h0, 32'hFFFF_FFFF, 1'b1);
    look("R5 zero enables", 200, 32'hA5A5_A5A5);
    put(200, 32'h0, 4'hF, 32'h0, 1'b1);
    look("R5 zero mask", 200, 32'hA5A5_A5A5);
  endtask

  task automatic t_sweep;
    int bad = 0;
    for (int w = 0; w < BYTES; w += 4) begin
      rda_addr = IDX_W'(w);
      rdb_addr = IDX_W'(w);
      #1;
      if (rda_data !== exp_word(w) || rdb_data !== exp_word(w)) begin
        bad++;
        if (bad < 4) $display("FAIL R5 sweep word %0d: got %08h expected %08h", w, rda_data, exp_word(w));
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0; wr_mask = '0;
    rda_addr = '0; rdb_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_fill;
    t_reset_keeps;
    t_bit_merge;
    t_byte_write;
    t_compose;
    t_lane_order;
    t_unaligned;
    t_wrap;
    t_second_port;
    t_no_effect;
    t_sweep;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule